// File: doc/BRIEF.md
# Toggle-Aware Line Send Selector

This block sits in front of a flit-serialized memory link. For each 128-byte cache line it decides whether the link should carry the compressed or the uncompressed form of the line. Both forms are split into 32-byte flits and sent one flit after another. The block counts how many link wires would change value between consecutive flits in each form, which is a measure of switching energy. It then weighs that count against the bandwidth saved by compression.

A requester presents the uncompressed line, the compressed bitstream and the compressed length in bytes, and selects a metric: energy times delay, or energy times delay squared. It then pulses `start_i`. The block walks the flit pairs one per cycle. It then reports the two toggle counts, a one-bit send decision and a one-cycle done pulse. Each line is judged on its own; nothing is carried from one line to the next.

Top module: `tac_send_select`

## Requirements
- R1: After reset, `done_o`, `send_comp_o`, `t0_o` and `t1_o` are all zero.
- R2: `t0_o` is the sum over k=1..3 of the popcount of (flit k XOR flit k-1) of the uncompressed line, where flit k is bits [256k+255:256k] (byte 0 in the low bits).
- R3: `t1_o` is computed the same way for the compressed data, but only over its first NC flits, where NC = ceil(length/32). Compressed bytes whose index is at or above the length are zeroed before counting.
- R4: A length of 0 counts as one flit (NC=1, so `t1_o`=0). A length above 128 counts as 128.
- R5: With `mode_i`=0 (linear), `send_comp_o`=1 exactly when NC<4 and t1·S < t0·128, where S=32·NC.
- R6: With `mode_i`=1 (quadratic), `send_comp_o`=1 exactly when NC<4 and t1·S² < t0·128².
- R7: When NC=4 (length 97..128 or above), `send_comp_o` is 0 regardless of the counts.
- R8: `done_o` is high for exactly one cycle, following the 4th rising edge after the edge that samples `start_i`. It is low on the edges before that.
- R9: `start_i` is ignored while a line is being processed. `t0_o`, `t1_o` and `send_comp_o` hold their values after done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin evaluating the presented line |
| mode_i | input | 1 | 0 linear metric, 1 quadratic metric |
| line_i | input | 1024 | Uncompressed line |
| comp_i | input | 1024 | Compressed bitstream, byte 0 in low bits |
| comp_len_i | input | 8 | Valid compressed length in bytes |
| send_comp_o | output | 1 | 1 send compressed, 0 send uncompressed |
| t0_o | output | 10 | Toggle count of the uncompressed form |
| t1_o | output | 10 | Toggle count of the compressed form |
| done_o | output | 1 | One-cycle result strobe |

## Verification
A wrong flit index or a missed padding mask shows up as a wrong `t0_o` or `t1_o` in the very cycle `done_o` rises. A wrong flit count shows up as a wrong decision near the length boundaries of 32, 96 and 97 bytes. A phase machine that re-accepts a start while busy, or never leaves its count phase, shows up as a done pulse that is missing, repeated or mistimed relative to the fourth edge. It also shows up as result values that change while the block should be idle. Random lines mix low-toggle and high-toggle patterns so that both outcomes of both metrics are reached.

// File: rtl/tac_pkg.sv
package tac_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_COUNT  = 2'd1,
        PH_DECIDE = 2'd2
    } phase_e;

    localparam logic METRIC_LINEAR = 1'b0;
    localparam logic METRIC_QUAD   = 1'b1;
endpackage

// File: rtl/tac_popcount.sv
module tac_popcount #(
    parameter int W = 256,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < W; i++) begin
            cnt_o = cnt_o + CW'(vec_i[i]);
        end
    end
endmodule

// File: rtl/tac_pad.sv
module tac_pad #(
    parameter int LINE_BYTES = 128,
    parameter int LENW = 8
) (
    input  logic [LINE_BYTES*8-1:0] data_i,
    input  logic [LENW-1:0]         len_i,
    output logic [LINE_BYTES*8-1:0] data_o
);
    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        assign data_o[b*8 +: 8] = (32'(len_i) > b) ? data_i[b*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/tac_decide.sv
module tac_decide #(
    parameter int NFLITS = 4,
    parameter int TW = 10,
    parameter int NCW = 3
) (
    input  logic [TW-1:0]  t0_i,
    input  logic [TW-1:0]  t1_i,
    input  logic [NCW-1:0] nc_i,
    input  logic           mode_i,
    output logic           send_o
);
    import tac_pkg::*;
    localparam int PW = TW + 2 * NCW + 2;

    logic [PW-1:0] lhs, rhs;

    always_comb begin
        lhs = PW'(t1_i) * PW'(nc_i);
        rhs = PW'(t0_i) * PW'(NFLITS);
        if (mode_i == METRIC_QUAD) begin
            lhs = lhs * PW'(nc_i);
            rhs = rhs * PW'(NFLITS);
        end
        send_o = (32'(nc_i) < NFLITS) && (lhs < rhs);
    end
endmodule

// File: rtl/tac_send_select.sv
module tac_send_select #(
    parameter int LINE_BYTES = 128,
    parameter int FLIT_BYTES = 32,
    localparam int NFLITS = LINE_BYTES / FLIT_BYTES,
    localparam int LW     = LINE_BYTES * 8,
    localparam int FW     = FLIT_BYTES * 8,
    localparam int LENW   = $clog2(LINE_BYTES + 1),
    localparam int NCW    = $clog2(NFLITS + 1),
    localparam int TW     = $clog2((NFLITS - 1) * FW + 1),
    localparam int PCW    = $clog2(FW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            mode_i,
    input  logic [LW-1:0]   line_i,
    input  logic [LW-1:0]   comp_i,
    input  logic [LENW-1:0] comp_len_i,
    output logic            send_comp_o,
    output logic [TW-1:0]   t0_o,
    output logic [TW-1:0]   t1_o,
    output logic            done_o
);
    import tac_pkg::*;

    typedef struct packed {
        phase_e          phase;
        logic [NCW-1:0]  idx;
        logic [NCW-1:0]  nc;
        logic            mode;
        logic [LW-1:0]   line;
        logic [LW-1:0]   comp;
        logic [TW-1:0]   t0;
        logic [TW-1:0]   t1;
        logic            send;
        logic            done;
    } state_t;

    state_t st_d, st_q;

    // length clamp and flit count of the incoming compressed line
    logic [LENW-1:0] len_clamped;
    logic [NCW-1:0]  nc_in;
    logic [LW-1:0]   comp_padded;

    always_comb begin
        len_clamped = (32'(comp_len_i) > LINE_BYTES) ? LENW'(LINE_BYTES) : comp_len_i;
        if (len_clamped == '0) nc_in = NCW'(1);
        else nc_in = NCW'((32'(len_clamped) + FLIT_BYTES - 1) / FLIT_BYTES);
    end

    tac_pad #(.LINE_BYTES(LINE_BYTES), .LENW(LENW)) u_pad (
        .data_i (comp_i),
        .len_i  (len_clamped),
        .data_o (comp_padded)
    );

    // current flit pair of each form
    logic [FW-1:0]  line_cur, line_prev, comp_cur, comp_prev;
    logic [PCW-1:0] pop_line, pop_comp;

    always_comb begin
        line_cur  = st_q.line[int'(st_q.idx) * FW +: FW];
        line_prev = st_q.line[(int'(st_q.idx) - 1) * FW +: FW];
        comp_cur  = st_q.comp[int'(st_q.idx) * FW +: FW];
        comp_prev = st_q.comp[(int'(st_q.idx) - 1) * FW +: FW];
    end

    tac_popcount #(.W(FW)) u_pop_line (
        .vec_i (line_cur ^ line_prev),
        .cnt_o (pop_line)
    );

    tac_popcount #(.W(FW)) u_pop_comp (
        .vec_i (comp_cur ^ comp_prev),
        .cnt_o (pop_comp)
    );

    logic decide_send;

    tac_decide #(.NFLITS(NFLITS), .TW(TW), .NCW(NCW)) u_decide (
        .t0_i   (st_q.t0),
        .t1_i   (st_q.t1),
        .nc_i   (st_q.nc),
        .mode_i (st_q.mode),
        .send_o (decide_send)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_COUNT;
                    st_d.idx   = NCW'(1);
                    st_d.nc    = nc_in;
                    st_d.mode  = mode_i;
                    st_d.line  = line_i;
                    st_d.comp  = comp_padded;
                    st_d.t0    = '0;
                    st_d.t1    = '0;
                    st_d.send  = 1'b0;
                end
            end
            PH_COUNT: begin
                st_d.t0 = st_q.t0 + TW'(pop_line);
                if (st_q.idx < st_q.nc) st_d.t1 = st_q.t1 + TW'(pop_comp);
                if (32'(st_q.idx) == NFLITS - 1) st_d.phase = PH_DECIDE;
                else st_d.idx = st_q.idx + NCW'(1);
            end
            PH_DECIDE: begin
                st_d.send  = decide_send;
                st_d.done  = 1'b1;
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign send_comp_o = st_q.send;
    assign t0_o        = st_q.t0;
    assign t1_o        = st_q.t1;
    assign done_o      = st_q.done;

    // R8: the result strobe never lasts two cycles
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: a full-size compressed line is never chosen
    p_full_uncomp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && 32'(st_q.nc) == NFLITS) |-> !send_comp_o);

    // R9: results hold while idle and no start arrives
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && !start_i) |=>
            ($stable(t0_o) && $stable(t1_o) && $stable(send_comp_o)));

    // R3: compressed toggles cannot exceed the pairs inside NC flits
    p_t1_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (32'(t1_o) <= (32'(st_q.nc) - 1) * FW));

    // R9: a start during counting does not restart the walk
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_COUNT && 32'(st_q.idx) != NFLITS - 1) |=> st_q.phase == PH_COUNT);
endmodule

// File: tb/tac_send_select_bench.sv
module tac_send_select_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LB = 128;
    localparam int FB = 32;
    localparam int NF = LB / FB;
    localparam int LW = LB * 8;
    localparam int FW = FB * 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic            mode_i = 1'b0;
    logic [LW-1:0]   line_i = '0;
    logic [LW-1:0]   comp_i = '0;
    logic [7:0]      comp_len_i = '0;
    logic            send_comp_o;
    logic [9:0]      t0_o, t1_o;
    logic            done_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tac_send_select u_tac_send_select (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .line_i(line_i), .comp_i(comp_i), .comp_len_i(comp_len_i),
        .send_comp_o(send_comp_o), .t0_o(t0_o), .t1_o(t1_o), .done_o(done_o)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_nc(int len);
        int l = (len > LB) ? LB : len;
        if (l == 0) return 1;
        return (l + FB - 1) / FB;
    endfunction

    function automatic int exp_toggles(logic [LW-1:0] d, int nflits);
        int s = 0;
        for (int k = 1; k < nflits; k++)
            s += $countones(d[k*FW +: FW] ^ d[(k-1)*FW +: FW]);
        return s;
    endfunction

    function automatic logic [LW-1:0] exp_pad(logic [LW-1:0] d, int len);
        logic [LW-1:0] r = d;
        for (int b = 0; b < LB; b++)
            if (b >= len) r[b*8 +: 8] = 8'h00;
        return r;
    endfunction

    function automatic int exp_send(int t0, int t1, int nc, bit quad);
        longint s = nc * FB;
        if (nc >= NF) return 0;
        if (!quad) return (t1 * s < t0 * LB) ? 1 : 0;
        return (t1 * s * s < longint'(t0) * LB * LB) ? 1 : 0;
    endfunction

    function automatic logic [LW-1:0] rand_line();
        logic [LW-1:0] r;
        for (int i = 0; i < LW / 32; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    function automatic logic [LW-1:0] quiet_line();
        logic [LW-1:0] r;
        logic [31:0] base = $urandom;
        for (int i = 0; i < LW / 32; i++) r[i*32 +: 32] = base + 32'(i % 8);
        return r;
    endfunction

    // one line evaluation; intrude=1 holds start high while busy (R9)
    task automatic run_line(logic [LW-1:0] ln, logic [LW-1:0] cp, int len,
                            bit quad, bit intrude);
        int nc = exp_nc(len);
        int lc = (len > LB) ? LB : len;
        int e0 = exp_toggles(ln, NF);
        int e1 = exp_toggles(exp_pad(cp, lc), nc);
        int es = exp_send(e0, e1, nc, quad);
        @(negedge clk);
        line_i = ln; comp_i = cp; comp_len_i = 8'(len); mode_i = quad; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = intrude;
        if (intrude) begin
            line_i = rand_line(); comp_i = rand_line(); comp_len_i = 8'd5; mode_i = ~quad;
        end
        repeat (NF - 1) @(posedge clk);
        @(negedge clk);
        chk("R8 done low before 4th edge", int'(done_o), 0);
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 done at 4th edge", int'(done_o), 1);
        chk("R2 t0", int'(t0_o), e0);
        chk("R3/R4 t1", int'(t1_o), e1);
        chk(quad ? "R6 quadratic decision" : "R5 linear decision", int'(send_comp_o), es);
        if (nc == NF) chk("R7 full length uncompressed", int'(send_comp_o), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R8 done single cycle", int'(done_o), 0);
        chk("R9 t0 held", int'(t0_o), e0);
        chk("R9 send held", int'(send_comp_o), es);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 done reset", int'(done_o), 0);
        chk("R1 send reset", int'(send_comp_o), 0);
        chk("R1 t0 reset", int'(t0_o), 0);
        chk("R1 t1 reset", int'(t1_o), 0);
        rst_n = 1'b1;

        // directed corners
        run_line(rand_line(), '0, 40, 1'b0, 1'b0);          // R5 zero comp toggles
        run_line('0, rand_line(), 40, 1'b0, 1'b0);          // R5 t0=0 never compress
        run_line(rand_line(), rand_line(), 0, 1'b1, 1'b0);  // R4 len 0
        run_line(rand_line(), rand_line(), 200, 1'b0, 1'b0);// R4 clamp, R7
        run_line(rand_line(), '0, 128, 1'b1, 1'b0);         // R7 full
        run_line(rand_line(), rand_line(), 97, 1'b0, 1'b0); // R7 boundary
        run_line(rand_line(), rand_line(), 96, 1'b1, 1'b0); // R6 3 flits
        run_line(rand_line(), rand_line(), 32, 1'b0, 1'b0); // R3 one flit
        run_line(rand_line(), rand_line(), 33, 1'b1, 1'b1); // R9 intrude, R3 pad
        run_line(quiet_line(), rand_line(), 64, 1'b0, 1'b1);// R9 intrude

        // random mix
        for (int n = 0; n < 60; n++) begin
            logic [LW-1:0] ln = ($urandom % 2) ? quiet_line() : rand_line();
            logic [LW-1:0] cp = ($urandom % 3 == 0) ? quiet_line() : rand_line();
            run_line(ln, cp, int'($urandom % 140), 1'($urandom), 1'($urandom % 4 == 0));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule